// File: doc/BRIEF.md
# Logical Shifted-Register Execution Unit

This block executes one 32-bit encoded bitwise-logic instruction per valid strobe. It splits the instruction word into its fields and drives two register-file read indices. It takes the two 64-bit operands that come back in the same cycle. The second operand is shifted or rotated by an immediate amount, optionally inverted, and combined with the first by AND, OR or XOR. The result is then written back through a write port.

The flag-setting forms also update a four-bit condition word. A 32-bit mode narrows the shift and the result to the low half and zero-extends the written value. Encodings the block cannot execute raise an undefined-instruction pulse and leave all state untouched. Register storage and instruction fetch live outside the block.

All outputs are registered. Every accepted instruction produces a one-cycle completion pulse on the following clock edge.

Top module: `logic_shift_exec`

## Requirements
- R1: Instruction fields are: bit 31 width select (1 = 64-bit), bits 30:29 operation code, bits 28:24 class pattern that must equal 5'b01010, bits 23:22 shift kind, bit 21 invert, bits 20:16 second source index, bits 15:10 shift amount, bits 9:5 first source index, bits 4:0 destination index. A class-pattern mismatch raises `undef_o` and performs no write and no flag update.
- R2: With {invert, opcode}, the operation is: 000 a AND b, 001 a OR b, 010 a XOR b, 011 a AND b with flags, 100 a AND NOT b, 101 a OR NOT b, 110 a XNOR b, 111 a AND NOT b with flags. Here a is the first source and b is the shifted second source.
- R3: The shift kind applies to the second source only: 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate right. An amount of 0 leaves the operand unchanged for every kind.
- R4: In 32-bit mode, the arithmetic shift copies bit 31 and the rotate works within 32 bits. The written result has bits 63:32 equal to zero.
- R5: 32-bit mode with shift-amount bit 5 set is undefined: `undef_o` pulses, with no write and no flag update.
- R6: Source index 31 reads as zero, whatever the register file returns for it.
- R7: Only opcode 3 updates `flags_o`, which is {N, Z, C, V} in bits 3..0. N is the result sign bit at the active width (bit 63 or bit 31). Z is set when the result is zero at the active width. C and V are 0. In all other cases the flags hold their value.
- R8: A write to destination index 31 is discarded (`wr_en_o` stays low). A flag update from such an instruction still takes place.
- R9: Results, the write strobe, the flag update and `undef_o` appear on the clock edge after `insn_valid_i`, together with a one-cycle `done_o` pulse. With no valid input, `done_o` stays low.
- R10: After reset, `done_o`, `undef_o`, `wr_en_o`, `flag_we_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Encoded instruction |
| rn_idx_o | output | 5 | First source register index |
| rn_data_i | input | 64 | First source read data |
| rm_idx_o | output | 5 | Second source register index |
| rm_data_i | input | 64 | Second source read data |
| wr_en_o | output | 1 | Result write strobe |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 64 | Result data |
| flag_we_o | output | 1 | Flags were updated this cycle |
| flags_o | output | 4 | Condition flags {N, Z, C, V} |
| done_o | output | 1 | Instruction completed |
| undef_o | output | 1 | Instruction was undefined |

## Verification
The bench builds the block with its default 64-bit data width and 32-entry index space. At this size the full cross of width mode, invert bit, opcode and shift kind can be swept. The sweep uses shift amounts that sit on the 0, 31/32 and 63 edges, over operand pairs chosen to produce zero, negative and mixed results. This reaches the rotate wrap-around and the sign fill in both widths. It also reaches the 32-bit rejection of large amounts and the zero and sign flags at each width. Directed cases cover index 31 as a source and as a destination, and a wrong class pattern.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    localparam int          INSN_W    = 32;
    localparam int          IDX_W     = 5;
    localparam int          AMT_W     = 6;
    localparam logic [4:0]  CLASS_PAT = 5'b01010;
    localparam logic [4:0]  ZERO_REG  = 5'd31;

    typedef enum logic [1:0] {
        SH_LEFT        = 2'd0,
        SH_RIGHT_LOG   = 2'd1,
        SH_RIGHT_ARITH = 2'd2,
        SH_ROTATE      = 2'd3
    } shift_kind_e;

    // {invert, opcode}
    typedef enum logic [2:0] {
        OP_AND   = 3'd0,
        OP_OR    = 3'd1,
        OP_XOR   = 3'd2,
        OP_ANDF  = 3'd3,
        OP_ANDN  = 3'd4,
        OP_ORNOT = 3'd5,
        OP_XNOR  = 3'd6,
        OP_ANDNF = 3'd7
    } logic_op_e;

    typedef struct packed {
        logic              wide;
        logic_op_e         op;
        shift_kind_e       kind;
        logic [AMT_W-1:0]  amt;
        logic [IDX_W-1:0]  rm;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rd;
        logic              set_flags;
        logic              illegal;
    } decoded_t;

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
    import lsx_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output decoded_t          dec_o
);
    always_comb begin
        dec_o.wide      = insn_i[31];
        dec_o.op        = logic_op_e'({insn_i[21], insn_i[30:29]});
        dec_o.kind      = shift_kind_e'(insn_i[23:22]);
        dec_o.rm        = insn_i[20:16];
        dec_o.amt       = insn_i[15:10];
        dec_o.rn        = insn_i[9:5];
        dec_o.rd        = insn_i[4:0];
        dec_o.set_flags = (insn_i[30:29] == 2'b11);
        dec_o.illegal   = (insn_i[28:24] != CLASS_PAT)
                        || (!insn_i[31] && insn_i[15]);
    end
endmodule

// File: rtl/lsx_shifter.sv
module lsx_shifter
    import lsx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  opnd_i,
    input  logic             wide_i,
    input  shift_kind_e      kind_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [XLEN-1:0]  opnd_o
);
    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN) + 1;

    logic [XLEN-1:0]  lo_mask;
    logic [XLEN-1:0]  lo_zext;
    logic [XLEN-1:0]  lo_sext;
    logic [CNT_W-1:0] amt_ext;
    logic [CNT_W-1:0] back_wide;
    logic [CNT_W-1:0] back_narrow;
    logic [XLEN-1:0]  wide_res;
    logic [XLEN-1:0]  narrow_res;

    always_comb begin
        lo_mask     = {{HALF{1'b0}}, {HALF{1'b1}}};
        lo_zext     = opnd_i & lo_mask;
        lo_sext     = {{HALF{opnd_i[HALF-1]}}, opnd_i[HALF-1:0]};
        amt_ext     = CNT_W'(amt_i);
        back_wide   = CNT_W'(XLEN) - amt_ext;
        back_narrow = CNT_W'(HALF) - amt_ext;

        unique case (kind_i)
            SH_LEFT:        wide_res = opnd_i << amt_ext;
            SH_RIGHT_LOG:   wide_res = opnd_i >> amt_ext;
            SH_RIGHT_ARITH: wide_res = XLEN'($signed(opnd_i) >>> amt_ext);
            default:        wide_res = (opnd_i >> amt_ext) | (opnd_i << back_wide);
        endcase

        unique case (kind_i)
            SH_LEFT:        narrow_res = lo_zext << amt_ext;
            SH_RIGHT_LOG:   narrow_res = lo_zext >> amt_ext;
            SH_RIGHT_ARITH: narrow_res = XLEN'($signed(lo_sext) >>> amt_ext);
            default:        narrow_res = (lo_zext >> amt_ext) | (lo_zext << back_narrow);
        endcase

        opnd_o = wide_i ? wide_res : (narrow_res & lo_mask);
    end
endmodule

// File: rtl/lsx_logic_unit.sv
module lsx_logic_unit
    import lsx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic_op_e        op_i,
    input  logic             wide_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output logic [XLEN-1:0]  res_o,
    output logic             neg_o,
    output logic             zero_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] keep;

    generate
        if (XLEN > HALF) begin : g_keep
            assign keep = wide_i ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
        end
    endgenerate

    always_comb begin
        b_eff = op_i[2] ? ~b_i : b_i;
        unique case (op_i[1:0])
            2'b01:   raw = a_i | b_eff;
            2'b10:   raw = a_i ^ b_eff;
            default: raw = a_i & b_eff;
        endcase
        res_o  = raw & keep;
        neg_o  = wide_i ? res_o[XLEN-1] : res_o[HALF-1];
        zero_o = (res_o == '0);
    end
endmodule

// File: rtl/logic_shift_exec.sv
module logic_shift_exec
    import lsx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid_i,
    input  logic [31:0]      insn_i,
    output logic [4:0]       rn_idx_o,
    input  logic [XLEN-1:0]  rn_data_i,
    output logic [4:0]       rm_idx_o,
    input  logic [XLEN-1:0]  rm_data_i,
    output logic             wr_en_o,
    output logic [4:0]       wr_idx_o,
    output logic [XLEN-1:0]  wr_data_o,
    output logic             flag_we_o,
    output logic [3:0]       flags_o,
    output logic             done_o,
    output logic             undef_o
);
    typedef struct packed {
        logic             done;
        logic             undef;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [XLEN-1:0]  wr_data;
        logic             flag_we;
        logic [3:0]       flags;
    } out_state_t;

    decoded_t        dec;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b_raw;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] result;
    logic            res_neg;
    logic            res_zero;
    out_state_t      st_d;
    out_state_t      st_q;

    lsx_decode u_decode (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    assign rn_idx_o   = dec.rn;
    assign rm_idx_o   = dec.rm;
    assign opnd_a     = (dec.rn == ZERO_REG) ? '0 : rn_data_i;
    assign opnd_b_raw = (dec.rm == ZERO_REG) ? '0 : rm_data_i;

    lsx_shifter #(.XLEN(XLEN)) u_shifter (
        .opnd_i (opnd_b_raw),
        .wide_i (dec.wide),
        .kind_i (dec.kind),
        .amt_i  (dec.amt),
        .opnd_o (opnd_b)
    );

    lsx_logic_unit #(.XLEN(XLEN)) u_logic (
        .op_i   (dec.op),
        .wide_i (dec.wide),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .res_o  (result),
        .neg_o  (res_neg),
        .zero_o (res_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = insn_valid_i;
        st_d.undef   = insn_valid_i && dec.illegal;
        st_d.wr_en   = insn_valid_i && !dec.illegal && (dec.rd != ZERO_REG);
        st_d.flag_we = insn_valid_i && !dec.illegal && dec.set_flags;
        if (insn_valid_i) begin
            st_d.wr_idx  = dec.rd;
            st_d.wr_data = result;
        end
        if (st_d.flag_we) begin
            st_d.flags = {res_neg, res_zero, 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign undef_o   = st_q.undef;
    assign wr_en_o   = st_q.wr_en;
    assign wr_idx_o  = st_q.wr_idx;
    assign wr_data_o = st_q.wr_data;
    assign flag_we_o = st_q.flag_we;
    assign flags_o   = st_q.flags;
endmodule

// File: rtl/lsx_checker.sv
module lsx_checker #(
    parameter int XLEN = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               insn_valid_i,
    input logic               in_wide,
    input logic [1:0]         in_opc,
    input logic [4:0]         in_class,
    input logic               in_amt_hi,
    input logic [4:0]         in_rd,
    input logic               wr_en_o,
    input logic [4:0]         wr_idx_o,
    input logic [XLEN/2-1:0]  wr_data_hi,
    input logic               flag_we_o,
    input logic [3:0]         flags_o,
    input logic               done_o,
    input logic               undef_o
);
    AST_CLASS_MISMATCH_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i && (in_class != 5'b01010) |=> undef_o && !wr_en_o && !flag_we_o); // R1

    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i && !in_wide |=> !wr_en_o || (wr_data_hi == '0)); // R4

    AST_NARROW_BIG_AMT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i && !in_wide && in_amt_hi |=> undef_o && !wr_en_o && !flag_we_o); // R5

    AST_FLAGS_ONLY_OPC3: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i && (in_opc != 2'b11) |=> !flag_we_o); // R7

    AST_FLAGS_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (flags_o[1:0] == 2'b00)); // R7

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_o |-> $stable(flags_o)); // R7

    AST_NO_ZERO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o != 5'd31)); // R8

    AST_DEST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i && (in_rd == 5'd31) |=> !wr_en_o); // R8

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i |=> done_o); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid_i |=> !done_o && !wr_en_o && !undef_o); // R9
endmodule

bind logic_shift_exec lsx_checker #(.XLEN(XLEN)) u_lsx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_valid_i (insn_valid_i),
    .in_wide      (insn_i[31]),
    .in_opc       (insn_i[30:29]),
    .in_class     (insn_i[28:24]),
    .in_amt_hi    (insn_i[15]),
    .in_rd        (insn_i[4:0]),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .wr_data_hi   (wr_data_o[XLEN-1:XLEN/2]),
    .flag_we_o    (flag_we_o),
    .flags_o      (flags_o),
    .done_o       (done_o),
    .undef_o      (undef_o)
);

// File: tb/logic_shift_exec_tb_top.sv
module logic_shift_exec_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [4:0]  rn_idx_o, rm_idx_o, wr_idx_o;
    logic [63:0] rn_data_i, rm_data_i, wr_data_o;
    logic        wr_en_o, flag_we_o, done_o, undef_o;
    logic [3:0]  flags_o;

    logic [63:0] rf [32];
    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] exp_flags = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rn_data_i = rf[rn_idx_o];
    assign rm_data_i = rf[rm_idx_o];

    logic_shift_exec dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid_i(insn_valid_i), .insn_i(insn_i),
        .rn_idx_o(rn_idx_o), .rn_data_i(rn_data_i),
        .rm_idx_o(rm_idx_o), .rm_data_i(rm_data_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .flag_we_o(flag_we_o), .flags_o(flags_o), .done_o(done_o), .undef_o(undef_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic wide, input logic [1:0] opc,
            input logic [1:0] kind, input logic inv, input logic [4:0] rm,
            input logic [5:0] amt, input logic [4:0] rn, input logic [4:0] rd);
        return {wide, opc, 5'b01010, kind, inv, rm, amt, rn, rd};
    endfunction

    // bit-by-bit reference of the shifter (R3, R4)
    function automatic logic [63:0] ref_shift(input logic wide, input logic [1:0] kind,
            input int amt, input logic [63:0] x);
        int w;
        logic [63:0] r;
        logic fill;
        w = wide ? 64 : 32;
        r = '0;
        fill = x[w-1];
        for (int i = 0; i < w; i++) begin
            case (kind)
                2'd0: r[i] = (i - amt >= 0) ? x[i - amt] : 1'b0;
                2'd1: r[i] = (i + amt < w) ? x[i + amt] : 1'b0;
                2'd2: r[i] = (i + amt < w) ? x[i + amt] : fill;
                default: r[i] = x[(i + amt) % w];
            endcase
        end
        return r;
    endfunction

    task automatic exec(input logic [31:0] ins, input string tag);
        logic wide, inv, und, exp_we;
        logic [1:0] opc;
        logic [4:0] rn, rm, rd;
        logic [63:0] a, b, res;
        logic [3:0] flg;
        wide = ins[31]; opc = ins[30:29]; inv = ins[21];
        rm = ins[20:16]; rn = ins[9:5]; rd = ins[4:0];
        und = (ins[28:24] != 5'b01010) || (!wide && ins[15]);
        a = (rn == 5'd31) ? 64'd0 : rf[rn];
        b = (rm == 5'd31) ? 64'd0 : rf[rm];
        b = ref_shift(wide, ins[23:22], int'(ins[15:10]), b);
        if (inv) b = ~b;
        case (opc)
            2'd1:    res = a | b;
            2'd2:    res = a ^ b;
            default: res = a & b;
        endcase
        if (!wide) res = {32'd0, res[31:0]};
        exp_we = !und && (rd != 5'd31);
        flg = exp_flags;
        if (!und && opc == 2'd3)
            flg = {wide ? res[63] : res[31], wide ? (res == 0) : (res[31:0] == 0), 2'b00};

        @(negedge clk);
        insn_i = ins;
        insn_valid_i = 1'b1;
        @(negedge clk);
        insn_valid_i = 1'b0;
        chk({tag, " R9 done"}, 64'(done_o), 64'd1);
        chk({tag, " R1/R5 undef"}, 64'(undef_o), 64'(und));
        chk({tag, " R8 wr_en"}, 64'(wr_en_o), 64'(exp_we));
        if (exp_we) begin
            chk({tag, " R2/R3/R4 data"}, wr_data_o, res);
            chk({tag, " R8 idx"}, 64'(wr_idx_o), 64'(rd));
        end
        chk({tag, " R7 flags"}, 64'(flags_o), 64'(flg));
        exp_flags = flg;
        @(negedge clk);
        chk({tag, " R9 idle"}, 64'({done_o, wr_en_o, undef_o}), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int amts [7] = '{0, 1, 5, 31, 32, 33, 63};
        logic [63:0] av [3] = '{64'hF00D_0000_8765_4321, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
        logic [63:0] bv [3] = '{64'h8000_0001_C000_00FF, 64'h0000_0000_0000_0000, 64'hFEDC_BA98_7654_3210};
        for (int i = 0; i < 32; i++) rf[i] = 64'hA5A5_0000_0000_0000 | 64'(i);
        rf[31] = 64'hDEAD_BEEF_CAFE_F00D;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs", 64'({done_o, undef_o, wr_en_o, flag_we_o, flags_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", 64'(done_o), 64'd0);

        for (int s = 0; s < 3; s++) begin
            rf[3] = av[s];
            rf[7] = bv[s];
            for (int w = 0; w < 2; w++)
                for (int n = 0; n < 2; n++)
                    for (int o = 0; o < 4; o++)
                        for (int k = 0; k < 4; k++)
                            for (int m = 0; m < 7; m++)
                                exec(enc(w[0], o[1:0], k[1:0], n[0], 5'd7, amts[m][5:0], 5'd3, 5'd5),
                                     "sweep");
        end

        // R6: index 31 as sources
        rf[7] = 64'h8123_4567_0000_0001;
        exec(enc(1'b1, 2'd1, 2'd0, 1'b0, 5'd7, 6'd0, 5'd31, 5'd9), "R6 rn zero");
        exec(enc(1'b0, 2'd1, 2'd0, 1'b1, 5'd7, 6'd0, 5'd31, 5'd9), "R6 rn zero narrow not");
        exec(enc(1'b1, 2'd1, 2'd0, 1'b0, 5'd31, 6'd4, 5'd3, 5'd9), "R6 rm zero");
        exec(enc(1'b1, 2'd3, 2'd0, 1'b0, 5'd31, 6'd0, 5'd3, 5'd9), "R6 R7 ands zero");
        // R8: destination 31 with flags (test form)
        rf[3] = 64'h8000_0000_0000_0000;
        rf[7] = 64'hFFFF_FFFF_FFFF_FFFF;
        exec(enc(1'b1, 2'd3, 2'd0, 1'b0, 5'd7, 6'd0, 5'd3, 5'd31), "R8 R7 test form");
        exec(enc(1'b0, 2'd0, 2'd0, 1'b0, 5'd7, 6'd0, 5'd3, 5'd31), "R8 discard");
        // R1: wrong class pattern, flag-setting opcode must not touch flags
        exec(enc(1'b1, 2'd3, 2'd0, 1'b0, 5'd7, 6'd0, 5'd31, 5'd2) ^ 32'h0100_0000, "R1 class bad");
        exec(enc(1'b1, 2'd0, 2'd0, 1'b0, 5'd7, 6'd0, 5'd3, 5'd2) & 32'hF7FF_FFFF, "R1 class bad2");
        // R5: narrow with amount bit 5, flag-setting form
        exec(enc(1'b0, 2'd3, 2'd1, 1'b1, 5'd7, 6'd40, 5'd3, 5'd2), "R5 narrow big amt");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule